// File: doc/BRIEF.md
# Byte-Wide Stack Processor Core

This block is a small multi-cycle processor with an 8-bit datapath. One 256-byte memory holds both the program and its data. The core has eight 8-bit general registers, a program counter, a stack pointer that grows downward, and a 3-bit condition register. Each instruction takes two clock cycles. In the first cycle the core latches the opcode byte and the two bytes that follow it. In the second cycle it executes the instruction and moves the program counter past the operand bytes that opcode uses. Operand bytes name registers through their low three bits. The one exception is the second byte of a load-immediate, which is a literal value.

Programs are written into the memory through a byte write port, and only while reset is held. When reset is released, execution starts at address 0. A print instruction places a register value on an output bus and raises a one-cycle valid strobe. A halt instruction, or running off the end of memory, stops the core. It then stays stopped until the next reset.

Top module: `stack_cpu8`

## Requirements
- R1: While `rst` is high, `halted` and `printValid` are low. After `rst` falls, execution starts at address 0x00, with the stack pointer at 0xF4 and the condition register at 0.
- R2: A write on the load port (`loadEn`, `loadAddr`, `loadData`) stores a byte into memory only while `rst` is high. When `rst` is low, the load port has no effect.
- R3: Opcode 0x82 (load-immediate, 3 bytes) writes its second operand byte into the register named by the low 3 bits of its first operand byte.
- R4: Opcode 0x47 (print, 2 bytes) raises `printValid` for exactly one cycle, with `printData` equal to the value of the named register.
- R5: Opcode 0xA0 (add) and opcode 0xA2 (multiply) are 3 bytes long. Each writes the low 8 bits of (first register op second register) back into the first register.
- R6: Opcode 0x45 (push, 2 bytes) first decrements the stack pointer and then stores the register at the new stack pointer. Opcode 0x46 (pop, 2 bytes) loads the byte at the stack pointer into the register and then increments the stack pointer.
- R7: Opcode 0xA7 (compare, 3 bytes) compares the two registers as unsigned values. It replaces the condition register with 0b001 for equal, 0b010 for greater-than, or 0b100 for less-than.
- R8: Opcode 0x54 (jump) sets the PC to the named register's value. Opcode 0x55 does this only when the condition register equals 0b001. Opcode 0x56 does this only when the condition register is anything else. A conditional jump that is not taken advances the PC by 2.
- R9: Opcode 0x50 (call) pushes the address two bytes past itself and then jumps to the named register's value. Opcode 0x11 (return) pops one byte into the PC.
- R10: Opcode 0x01 stops execution. `halted` then stays high, and no further print occurs, until reset.
- R11: Any other opcode is skipped by advancing the PC by 1. If the unknown opcode sits at address 0xFF, the core halts instead of wrapping around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables program loading |
| loadEn | input | 1 | Memory load strobe (honoured during reset only) |
| loadAddr | input | 8 | Memory load address |
| loadData | input | 8 | Memory load byte |
| printValid | output | 1 | One-cycle strobe for a print instruction |
| printData | output | 8 | Printed register value |
| halted | output | 1 | High once the core has stopped |

## Verification
Arithmetic programs check register addressing through the low index bits. They use operands whose sum or product overflows 8 bits, so that wrap-around can be told apart from saturation. Stack programs pop before any push and then pop in reverse order, which separates the stack pointer's reset value from the order of pre-decrement and post-increment. Jump programs compare less-than, greater-than and equal operands, and also start from the cleared condition register, which separates the two conditional jumps and the not-taken advance. Further runs cover call and return, a stray opcode, the end-of-memory halt, and a load attempt made while the core runs.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int WORD_W    = 8;
  localparam int MEM_DEPTH = 1 << WORD_W;

  localparam logic [WORD_W-1:0] OP_HLT  = 8'h01;
  localparam logic [WORD_W-1:0] OP_LDI  = 8'h82;
  localparam logic [WORD_W-1:0] OP_PRN  = 8'h47;
  localparam logic [WORD_W-1:0] OP_MUL  = 8'hA2;
  localparam logic [WORD_W-1:0] OP_ADD  = 8'hA0;
  localparam logic [WORD_W-1:0] OP_PUSH = 8'h45;
  localparam logic [WORD_W-1:0] OP_POP  = 8'h46;
  localparam logic [WORD_W-1:0] OP_CALL = 8'h50;
  localparam logic [WORD_W-1:0] OP_RET  = 8'h11;
  localparam logic [WORD_W-1:0] OP_JMP  = 8'h54;
  localparam logic [WORD_W-1:0] OP_CMP  = 8'hA7;
  localparam logic [WORD_W-1:0] OP_JEQ  = 8'h55;
  localparam logic [WORD_W-1:0] OP_JNE  = 8'h56;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_t;

  typedef enum logic [2:0] {
    PC_HOLD, PC_ADV1, PC_ADV2, PC_ADV3, PC_REG, PC_STACK
  } pcSel_t;

  typedef enum logic [1:0] {WB_IMM, WB_ADD, WB_MUL, WB_STACK} wbSel_t;

  typedef struct packed {
    logic   latchIr;
    logic   regWr;
    wbSel_t wbSel;
    pcSel_t pcSel;
    logic   spDec;
    logic   spInc;
    logic   memWr;
    logic   pushPc;
    logic   flagWr;
    logic   emit;
  } ctrl_t;
endpackage

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
  import cpu8_pkg::*;
#(
  parameter int                NUM_REGS = 8,
  parameter logic [WORD_W-1:0] SP_INIT  = 8'hF4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  ctrl_t             ctrl,
  output logic [WORD_W-1:0] ir,
  output logic              flagEq,
  output logic              pcAtEnd,
  output logic              printValid,
  output logic [WORD_W-1:0] printData
);
  localparam int RIDX_W = $clog2(NUM_REGS);

  logic [WORD_W-1:0] mem  [MEM_DEPTH];
  logic [WORD_W-1:0] regs [NUM_REGS];
  logic [WORD_W-1:0] pc, sp, opB;
  logic [RIDX_W-1:0] ra;
  logic [2:0]        flags;

  logic [WORD_W-1:0] valA, valB, sum, prod, wbVal, topVal, spDown;
  assign valA    = regs[ra];
  assign valB    = regs[opB[RIDX_W-1:0]];
  assign sum     = valA + valB;
  assign prod    = valA * valB;
  assign topVal  = mem[sp];
  assign spDown  = sp - 8'd1;
  assign flagEq  = (flags == 3'b001);
  assign pcAtEnd = (pc == {WORD_W{1'b1}});

  always_comb begin
    case (ctrl.wbSel)
      WB_ADD:   wbVal = sum;
      WB_MUL:   wbVal = prod;
      WB_STACK: wbVal = topVal;
      default:  wbVal = opB;
    endcase
  end

  // memory: loader during reset, stack pushes otherwise
  always_ff @(posedge clk) begin
    if (rst) begin
      if (loadEn) mem[loadAddr] <= loadData;
    end else if (ctrl.memWr) begin
      mem[spDown] <= ctrl.pushPc ? (pc + 8'd2) : valA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      pc         <= '0;
      sp         <= SP_INIT;
      flags      <= '0;
      ir         <= '0;
      ra         <= '0;
      opB        <= '0;
      printValid <= 1'b0;
      printData  <= '0;
    end else begin
      if (ctrl.latchIr) begin
        ir  <= mem[pc];
        ra  <= mem[pc + 8'd1][RIDX_W-1:0];
        opB <= mem[pc + 8'd2];
      end
      if (ctrl.regWr) regs[ra] <= wbVal;
      if (ctrl.flagWr) begin
        if (valA == valB)     flags <= 3'b001;
        else if (valA < valB) flags <= 3'b100;
        else                  flags <= 3'b010;
      end
      if (ctrl.spDec)      sp <= spDown;
      else if (ctrl.spInc) sp <= sp + 8'd1;
      case (ctrl.pcSel)
        PC_ADV1:  pc <= pc + 8'd1;
        PC_ADV2:  pc <= pc + 8'd2;
        PC_ADV3:  pc <= pc + 8'd3;
        PC_REG:   pc <= valA;
        PC_STACK: pc <= topVal;
        default:  pc <= pc;
      endcase
      printValid <= ctrl.emit;
      if (ctrl.emit) printData <= valA;
    end
  end

  // R7: compare leaves at most one condition bit set
  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags));

  // R6: a register push lands at the new top of stack
  assert_push_top_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.memWr && !ctrl.pushPc) |=> (mem[sp] == $past(valA)));

  // R9: a call leaves its return address on top of stack
  assert_call_link_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.memWr && ctrl.pushPc) |=> (mem[sp] == $past(pc) + 8'd2));

  // R4: print strobe follows only a print opcode
  assert_print_src_R4: assert property (@(posedge clk) disable iff (rst)
    printValid |-> ($past(ir) == OP_PRN));

  // R2: load port leaves memory untouched while running
  assert_load_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (loadEn && !ctrl.memWr) |=> (mem[$past(loadAddr)] == $past(mem[loadAddr])));
endmodule

// File: rtl/cpu8_control.sv
module cpu8_control
  import cpu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ir,
  input  logic              flagEq,
  input  logic              pcAtEnd,
  output ctrl_t             ctrl,
  output logic              halted
);
  state_t state, nextState;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    case (state)
      ST_FETCH: begin
        ctrl.latchIr = 1'b1;
        nextState    = ST_EXEC;
      end
      ST_EXEC: begin
        nextState = ST_FETCH;
        case (ir)
          OP_HLT: nextState = ST_HALT;
          OP_LDI: begin ctrl.regWr = 1'b1; ctrl.wbSel = WB_IMM; ctrl.pcSel = PC_ADV3; end
          OP_ADD: begin ctrl.regWr = 1'b1; ctrl.wbSel = WB_ADD; ctrl.pcSel = PC_ADV3; end
          OP_MUL: begin ctrl.regWr = 1'b1; ctrl.wbSel = WB_MUL; ctrl.pcSel = PC_ADV3; end
          OP_CMP: begin ctrl.flagWr = 1'b1; ctrl.pcSel = PC_ADV3; end
          OP_PRN: begin ctrl.emit = 1'b1; ctrl.pcSel = PC_ADV2; end
          OP_PUSH: begin ctrl.memWr = 1'b1; ctrl.spDec = 1'b1; ctrl.pcSel = PC_ADV2; end
          OP_POP: begin
            ctrl.regWr = 1'b1; ctrl.wbSel = WB_STACK; ctrl.spInc = 1'b1; ctrl.pcSel = PC_ADV2;
          end
          OP_CALL: begin
            ctrl.memWr = 1'b1; ctrl.pushPc = 1'b1; ctrl.spDec = 1'b1; ctrl.pcSel = PC_REG;
          end
          OP_RET: begin ctrl.spInc = 1'b1; ctrl.pcSel = PC_STACK; end
          OP_JMP: ctrl.pcSel = PC_REG;
          OP_JEQ: ctrl.pcSel = flagEq ? PC_REG : PC_ADV2;
          OP_JNE: ctrl.pcSel = flagEq ? PC_ADV2 : PC_REG;
          default: begin
            if (pcAtEnd) nextState = ST_HALT;
            else         ctrl.pcSel = PC_ADV1;
          end
        endcase
      end
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  assign halted = (state == ST_HALT);

  // R10: once stopped, the core stays stopped
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R11: a stray opcode at the last address stops the core
  assert_end_stop_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && pcAtEnd && ctrl.pcSel == PC_HOLD && !ctrl.memWr) |=> halted);

  // R1: fetch and execute alternate
  assert_two_phase_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state != ST_FETCH));
endmodule

// File: rtl/stack_cpu8.sv
module stack_cpu8
  import cpu8_pkg::*;
#(
  parameter int                NUM_REGS = 8,
  parameter logic [WORD_W-1:0] SP_INIT  = 8'hF4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  output logic              printValid,
  output logic [WORD_W-1:0] printData,
  output logic              halted
);
  ctrl_t             ctrl;
  logic [WORD_W-1:0] ir;
  logic              flagEq, pcAtEnd;

  cpu8_control u_ctrl (
    .clk(clk), .rst(rst), .ir(ir), .flagEq(flagEq), .pcAtEnd(pcAtEnd),
    .ctrl(ctrl), .halted(halted)
  );

  cpu8_datapath #(.NUM_REGS(NUM_REGS), .SP_INIT(SP_INIT)) u_dp (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .ctrl(ctrl), .ir(ir), .flagEq(flagEq), .pcAtEnd(pcAtEnd),
    .printValid(printValid), .printData(printData)
  );
endmodule

// File: tb/stack_cpu8_tb.sv
`timescale 1ns/1ps
module stack_cpu8_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [7:0] loadAddr = '0, loadData = '0;
  logic       printValid, halted;
  logic [7:0] printData;

  int checks = 0, errors = 0;
  logic [7:0] img [256];
  logic [7:0] seen [64];
  int nSeen = 0;

  always #4 clk = ~clk;

  stack_cpu8 u_dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .printValid(printValid), .printData(printData), .halted(halted)
  );

  always @(negedge clk) if (!rst && printValid && nSeen < 64) begin
    seen[nSeen] = printData;
    nSeen++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearImg();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  task automatic put(input int addr, input logic [7:0] b);
    img[addr] = b;
  endtask

  task automatic loadImg();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      loadEn = 1'b1; loadAddr = 8'(i); loadData = img[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    check("R1 halted low in reset", halted, 0);
    check("R1 printValid low in reset", printValid, 0);
  endtask

  task automatic run(input bit poke, input logic [7:0] pAddr, input logic [7:0] pData);
    int cyc = 0;
    nSeen = 0;
    rst = 1'b0;
    if (poke) begin
      loadEn = 1'b1; loadAddr = pAddr; loadData = pData;
      repeat (3) @(negedge clk);
      loadEn = 1'b0;
    end
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    check("R10 program reached halt", halted, 1);
  endtask

  task automatic expectPrints(input string req, input int n, input logic [7:0] v0,
                              input logic [7:0] v1, input logic [7:0] v2,
                              input logic [7:0] v3, input logic [7:0] v4);
    logic [7:0] exp [5];
    exp[0] = v0; exp[1] = v1; exp[2] = v2; exp[3] = v3; exp[4] = v4;
    check({req, " print count"}, nSeen, n);
    for (int i = 0; i < n && i < nSeen; i++) check({req, " print value"}, seen[i], exp[i]);
  endtask

  // R3 R5 R4: loads, wrapping add and multiply, prints
  task automatic testArith();
    clearImg();
    put(0, 8'h82); put(1, 8'h00); put(2, 8'h08);
    put(3, 8'h82); put(4, 8'h09); put(5, 8'h03);
    put(6, 8'h47); put(7, 8'h01);
    put(8, 8'hA0); put(9, 8'h00); put(10, 8'h01);
    put(11, 8'h47); put(12, 8'h00);
    put(13, 8'h82); put(14, 8'h02); put(15, 8'h20);
    put(16, 8'h82); put(17, 8'h03); put(18, 8'h10);
    put(19, 8'hA2); put(20, 8'h02); put(21, 8'h03);
    put(22, 8'h47); put(23, 8'h02);
    put(24, 8'h82); put(25, 8'h04); put(26, 8'hF0);
    put(27, 8'h82); put(28, 8'h05); put(29, 8'h20);
    put(30, 8'hA0); put(31, 8'h04); put(32, 8'h05);
    put(33, 8'h47); put(34, 8'h04);
    put(35, 8'h01);
    loadImg();
    run(0, 8'h00, 8'h00);
    expectPrints("R3 R4 R5 arithmetic", 4, 8'h03, 8'h0B, 8'h00, 8'h10, 8'h00);
    repeat (30) @(negedge clk);
    check("R10 halted stays high", halted, 1);
    check("R10 no print after halt", nSeen, 4);
  endtask

  // R6: stack pointer reset value and push/pop order
  task automatic testStack();
    clearImg();
    put(8'hF4, 8'h5A);
    put(0, 8'h46); put(1, 8'h02);
    put(2, 8'h47); put(3, 8'h02);
    put(4, 8'h82); put(5, 8'h00); put(6, 8'h11);
    put(7, 8'h82); put(8, 8'h01); put(9, 8'h22);
    put(10, 8'h45); put(11, 8'h00);
    put(12, 8'h45); put(13, 8'h01);
    put(14, 8'h46); put(15, 8'h03);
    put(16, 8'h46); put(17, 8'h04);
    put(18, 8'h47); put(19, 8'h03);
    put(20, 8'h47); put(21, 8'h04);
    put(22, 8'h01);
    loadImg();
    run(0, 8'h00, 8'h00);
    expectPrints("R6 R1 stack", 3, 8'h5A, 8'h22, 8'h11, 8'h00, 8'h00);
  endtask

  // R7 R8: compare outcomes against both conditional jumps and plain jump
  task automatic testBranch();
    clearImg();
    put(0, 8'h82); put(1, 8'h07); put(2, 8'h0B);
    put(3, 8'h56); put(4, 8'h07);
    put(5, 8'h82); put(6, 8'h06); put(7, 8'hEE); put(8, 8'h47); put(9, 8'h06); put(10, 8'h01);
    put(11, 8'h82); put(12, 8'h00); put(13, 8'h05);
    put(14, 8'h82); put(15, 8'h01); put(16, 8'h09);
    put(17, 8'hA7); put(18, 8'h00); put(19, 8'h01);
    put(20, 8'h82); put(21, 8'h07); put(22, 8'h3A);
    put(23, 8'h55); put(24, 8'h07);
    put(25, 8'h82); put(26, 8'h02); put(27, 8'h01); put(28, 8'h47); put(29, 8'h02);
    put(30, 8'hA7); put(31, 8'h01); put(32, 8'h00);
    put(33, 8'h55); put(34, 8'h07);
    put(35, 8'h82); put(36, 8'h02); put(37, 8'h02); put(38, 8'h47); put(39, 8'h02);
    put(40, 8'hA7); put(41, 8'h00); put(42, 8'h00);
    put(43, 8'h56); put(44, 8'h07);
    put(45, 8'h82); put(46, 8'h02); put(47, 8'h03); put(48, 8'h47); put(49, 8'h02);
    put(50, 8'h55); put(51, 8'h07);
    put(52, 8'h82); put(53, 8'h02); put(54, 8'hEE); put(55, 8'h47); put(56, 8'h02); put(57, 8'h01);
    put(58, 8'h82); put(59, 8'h02); put(60, 8'h04); put(61, 8'h47); put(62, 8'h02);
    put(63, 8'h82); put(64, 8'h07); put(65, 8'h4A);
    put(66, 8'h54); put(67, 8'h07);
    put(68, 8'h82); put(69, 8'h02); put(70, 8'hEE); put(71, 8'h47); put(72, 8'h02); put(73, 8'h01);
    put(74, 8'h47); put(75, 8'h00);
    put(76, 8'h01);
    loadImg();
    run(0, 8'h00, 8'h00);
    expectPrints("R7 R8 branch", 5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
  endtask

  // R9: call pushes link two past itself, return pops it
  task automatic testCall();
    clearImg();
    put(0, 8'h82); put(1, 8'h01); put(2, 8'h08);
    put(3, 8'h50); put(4, 8'h01);
    put(5, 8'h47); put(6, 8'h00);
    put(7, 8'h01);
    put(8, 8'h82); put(9, 8'h00); put(10, 8'h77);
    put(11, 8'h46); put(12, 8'h03);
    put(13, 8'h47); put(14, 8'h03);
    put(15, 8'h45); put(16, 8'h03);
    put(17, 8'h11);
    loadImg();
    run(0, 8'h00, 8'h00);
    expectPrints("R9 call return", 2, 8'h05, 8'h77, 8'h00, 8'h00, 8'h00);
  endtask

  // R11: stray opcodes skipped; stop at last address
  task automatic testUnknown();
    clearImg();
    put(0, 8'hFF); put(1, 8'h00);
    put(2, 8'h82); put(3, 8'h00); put(4, 8'h2A);
    put(5, 8'h47); put(6, 8'h00);
    put(7, 8'h82); put(8, 8'h01); put(9, 8'hF0);
    put(10, 8'h54); put(11, 8'h01);
    loadImg();
    run(0, 8'h00, 8'h00);
    expectPrints("R11 skip and end stop", 1, 8'h2A, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  // R2: load attempt while running is ignored
  task automatic testLoadLock();
    clearImg();
    put(40, 8'h82); put(41, 8'h00); put(42, 8'h33);
    put(43, 8'h47); put(44, 8'h00);
    put(45, 8'h01);
    loadImg();
    run(1, 8'd42, 8'h99);
    expectPrints("R2 load ignored when running", 1, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testArith();
    testStack();
    testBranch();
    testCall();
    testUnknown();
    testLoadLock();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule